// File: doc/BRIEF.md
# Resolver Signal Degradation Monitor

This block watches a stream of unsigned monitor magnitudes and drives an active-low degradation flag. The magnitudes are formed upstream from a resolver's sine and cosine channels. Two separate causes can pull the flag low. The first is an overrange check. Each valid sample is compared against an upper limit, and the result follows the most recent valid sample with no memory. The second is a spread check. The block keeps the smallest and largest magnitudes seen so far and flags when their difference goes above a programmable limit. That cause is latched. It stays latched until a rising edge on an asynchronous re-arm strobe clears it and empties the extreme trackers.

The sample input is a valid-qualified stream with no back-pressure. There is no ready signal, and the block takes every beat on which the valid input is high, in the same cycle. The two limits and the strobe are plain control pins. The stored minimum and maximum are driven out so that a system controller can read the measured spread.

Top module: `resolver_degrade_monitor`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it falls, `deg_n` is 1 and both `min_mag` and `max_mag` are 0. No extreme is held after reset.
- R2: A valid sample with `mag` strictly greater than `over_lim` makes `deg_n` 0 in the cycle after the sample. A sample equal to `over_lim` does not raise this cause.
- R3: The overrange cause is not latched. The next valid sample at or below `over_lim` removes it in the following cycle. Samples with valid low leave it as it is.
- R4: The first valid sample after reset or after a re-arm loads both `min_mag` and `max_mag`. Each later valid sample lowers `min_mag` or raises `max_mag` when it lies outside them. The new values appear in the cycle after the sample.
- R5: Samples with `mag_valid` low have no effect: `min_mag`, `max_mag` and `deg_n` stay as they were.
- R6: Once at least one sample is held, `max_mag - min_mag` strictly greater than `spread_lim` makes `deg_n` 0. This happens one cycle after the extremes show that spread. A spread equal to the limit does not raise this cause.
- R7: The spread cause stays latched while the flag is low, even when later samples are in range. It is released only by a re-arm or by reset.
- R8: `rearm` passes through a two-stage synchronizer. Its rising edge takes effect at the third rising clock edge after `rearm` goes high. That clock edge clears the spread latch and empties the trackers, and `min_mag`/`max_mag` keep their old values until the next valid sample reloads them. A level held high re-arms only once.
- R9: `deg_n` is 1 only when neither the overrange cause nor the spread latch is active (1 = healthy, 0 = degraded).
- R10: A valid sample that arrives in the same clock edge as the re-arm loads both extremes with that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mag_valid | input | 1 | Qualifies `mag` for this cycle |
| mag | input | W (12) | Unsigned monitor magnitude |
| over_lim | input | W (12) | Overrange limit, strictly-greater compare |
| spread_lim | input | W (12) | Maximum allowed max-min spread |
| rearm | input | 1 | Asynchronous strobe, rising edge re-arms the spread check |
| deg_n | output | 1 | Degradation flag, 0 = degraded |
| min_mag | output | W (12) | Smallest magnitude held since the last re-arm |
| max_mag | output | W (12) | Largest magnitude held since the last re-arm |

## Verification
The hardest case to reach from the ports is a valid sample that lands exactly on the clock edge where a synchronized strobe edge acts. In that case the sample must reload the trackers rather than be lost. The bench counts edges from the moment it raises `rearm` and places a valid sample on the third edge. It also holds the strobe high across later samples to show that a level does not re-arm again. Limit and spread sweeps step the spread through one below, equal to and above each limit, so the strictly-greater boundaries are tested at the edge.

// File: rtl/rsdm_pkg.sv
package rsdm_pkg;
  localparam int unsigned DEF_WIDTH       = 12;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    TRK_EMPTY = 2'b00,
    TRK_HELD  = 2'b01
  } trk_state_e;
endpackage

// File: rtl/rsdm_edge_sync.sv
module rsdm_edge_sync #(
  parameter int unsigned STAGES = rsdm_pkg::DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= async_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= 1'b0;
      else     chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/rsdm_extreme_tracker.sv
module rsdm_extreme_tracker #(
  parameter int unsigned W = rsdm_pkg::DEF_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rearm,
  input  logic         in_valid,
  input  logic [W-1:0] in_mag,
  output logic         seeded,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic [W-1:0] spread
);
  import rsdm_pkg::*;

  trk_state_e state_q;
  logic [W-1:0] lo_q, hi_q;
  logic load_fresh;

  assign load_fresh = rearm || (state_q == TRK_EMPTY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TRK_EMPTY;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (load_fresh) begin
      if (in_valid) begin
        state_q <= TRK_HELD;
        lo_q    <= in_mag;
        hi_q    <= in_mag;
      end else begin
        state_q <= TRK_EMPTY;
      end
    end else if (in_valid) begin
      if (in_mag < lo_q) lo_q <= in_mag;
      if (in_mag > hi_q) hi_q <= in_mag;
    end
  end

  assign seeded = (state_q == TRK_HELD);
  assign lo     = lo_q;
  assign hi     = hi_q;
  assign spread = hi_q - lo_q;
endmodule

// File: rtl/rsdm_fault_combine.sv
module rsdm_fault_combine #(
  parameter int unsigned W = rsdm_pkg::DEF_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rearm,
  input  logic         in_valid,
  input  logic [W-1:0] in_mag,
  input  logic [W-1:0] over_lim,
  input  logic         seeded,
  input  logic [W-1:0] spread,
  input  logic [W-1:0] spread_lim,
  output logic         deg_n
);
  logic over_q;
  logic latch_q;
  logic spread_bad;

  assign spread_bad = seeded && (spread > spread_lim);

  always_ff @(posedge clk) begin
    if (rst)           over_q <= 1'b0;
    else if (in_valid) over_q <= (in_mag > over_lim);
  end

  always_ff @(posedge clk) begin
    if (rst)        latch_q <= 1'b0;
    else if (rearm) latch_q <= 1'b0;
    else            latch_q <= latch_q | spread_bad;
  end

  assign deg_n = ~(over_q | latch_q);
endmodule

// File: rtl/resolver_degrade_monitor.sv
module resolver_degrade_monitor #(
  parameter int unsigned W           = rsdm_pkg::DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = rsdm_pkg::DEF_SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mag_valid,
  input  logic [W-1:0] mag,
  input  logic [W-1:0] over_lim,
  input  logic [W-1:0] spread_lim,
  input  logic         rearm,
  output logic         deg_n,
  output logic [W-1:0] min_mag,
  output logic [W-1:0] max_mag
);
  logic         rearm_edge;
  logic         seeded;
  logic [W-1:0] spread;

  rsdm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (rearm),
    .rise     (rearm_edge)
  );

  rsdm_extreme_tracker #(.W(W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .rearm    (rearm_edge),
    .in_valid (mag_valid),
    .in_mag   (mag),
    .seeded   (seeded),
    .lo       (min_mag),
    .hi       (max_mag),
    .spread   (spread)
  );

  rsdm_fault_combine #(.W(W)) u_fault (
    .clk        (clk),
    .rst        (rst),
    .rearm      (rearm_edge),
    .in_valid   (mag_valid),
    .in_mag     (mag),
    .over_lim   (over_lim),
    .seeded     (seeded),
    .spread     (spread),
    .spread_lim (spread_lim),
    .deg_n      (deg_n)
  );
endmodule

// File: rtl/rsdm_checker.sv
module rsdm_checker #(
  parameter int unsigned W = rsdm_pkg::DEF_WIDTH
) (
  input logic         clk,
  input logic         rst,
  input logic         mag_valid,
  input logic [W-1:0] mag,
  input logic [W-1:0] over_lim,
  input logic [W-1:0] spread_lim,
  input logic         rearm_edge,
  input logic         seeded,
  input logic         deg_n,
  input logic [W-1:0] min_mag,
  input logic [W-1:0] max_mag
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (deg_n && min_mag == '0 && max_mag == '0 && !seeded));

  // R2
  over_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (mag_valid && mag > over_lim) |=> !deg_n);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mag_valid && !rearm_edge) |=> ($stable(min_mag) && $stable(max_mag)));

  // R6
  spread_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (seeded && !rearm_edge && (max_mag - min_mag > spread_lim)) |=> !deg_n);

  // R8
  rearm_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (rearm_edge && !mag_valid) |=> !seeded);

  // R10
  rearm_seed_chk: assert property (@(posedge clk) disable iff (rst)
    (rearm_edge && mag_valid) |=> (seeded && min_mag == $past(mag) && max_mag == $past(mag)));

  // R4
  always @(posedge clk) begin
    if (!rst) begin
      order_chk: assert (min_mag <= max_mag);
    end
  end
endmodule

bind resolver_degrade_monitor rsdm_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mag_valid  (mag_valid),
  .mag        (mag),
  .over_lim   (over_lim),
  .spread_lim (spread_lim),
  .rearm_edge (rearm_edge),
  .seeded     (seeded),
  .deg_n      (deg_n),
  .min_mag    (min_mag),
  .max_mag    (max_mag)
);

// File: tb/resolver_degrade_monitor_test.sv
`timescale 1ns/1ps
module resolver_degrade_monitor_test;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst;
  logic         mag_valid;
  logic [W-1:0] mag;
  logic [W-1:0] over_lim;
  logic [W-1:0] spread_lim;
  logic         rearm;
  logic         deg_n;
  logic [W-1:0] min_mag;
  logic [W-1:0] max_mag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state, built from the requirements
  logic         m_over, m_latch, m_held;
  logic [W-1:0] m_lo, m_hi;
  logic         m_s1, m_s2, m_s3;

  always #5 clk = ~clk;

  resolver_degrade_monitor #(.W(W)) uut (
    .clk(clk), .rst(rst), .mag_valid(mag_valid), .mag(mag),
    .over_lim(over_lim), .spread_lim(spread_lim), .rearm(rearm),
    .deg_n(deg_n), .min_mag(min_mag), .max_mag(max_mag)
  );

  task automatic model_reset();
    m_over = 0; m_latch = 0; m_held = 0; m_lo = '0; m_hi = '0;
    m_s1 = 0; m_s2 = 0; m_s3 = 0;
  endtask

  task automatic model_edge();
    logic edge_now, bad;
    edge_now = m_s2 & ~m_s3;                                   // R8
    bad      = m_held && ((m_hi - m_lo) > spread_lim);          // R6
    m_latch  = edge_now ? 1'b0 : (m_latch | bad);               // R7
    if (mag_valid) m_over = (mag > over_lim);                   // R2 R3
    if (edge_now || !m_held) begin                              // R4 R10
      if (mag_valid) begin m_held = 1; m_lo = mag; m_hi = mag; end
      else m_held = 0;
    end else if (mag_valid) begin
      if (mag < m_lo) m_lo = mag;
      if (mag > m_hi) m_hi = mag;
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = rearm;
  endtask

  task automatic compare(input string tag);
    logic exp_deg;
    exp_deg = ~(m_over | m_latch);                              // R9
    n_cmp++;
    if (deg_n !== exp_deg || min_mag !== m_lo || max_mag !== m_hi) begin
      n_bad++;
      $display("FAIL %s: deg_n=%0b min=%0d max=%0d expected deg_n=%0b min=%0d max=%0d",
               tag, deg_n, min_mag, max_mag, exp_deg, m_lo, m_hi);
    end
  endtask

  task automatic step(input logic v, input int d, input logic s, input string tag);
    mag_valid = v; mag = W'(d); rearm = s;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic rearm_pulse(input string tag);
    step(0, 0, 1, tag);
    step(0, 0, 0, tag);
    step(0, 0, 0, tag);
    step(0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; mag_valid = 0; mag = '0; rearm = 0;
    over_lim = 12'd4095; spread_lim = 12'd4095;
    model_reset();
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst = 0;
    @(posedge clk); model_edge(); @(negedge clk);
    compare("R1 after reset");

    // R2 R3: overrange sweep across the limit, each followed by an in-range sample
    over_lim = 12'd100;
    for (int d = 94; d <= 106; d++) begin
      rearm_pulse("R8 clear before overrange");
      step(1, d, 0, "R2 overrange compare");
      step(1, 50, 0, "R3 overrange not held");
    end
    over_lim = 12'd4095; spread_lim = 12'd4095;
    rearm_pulse("R8 clear");
    for (int d = 4090; d <= 4095; d++) step(1, d, 0, "R2 top of range");

    // R6 R7: spread sweep around several limits
    foreach (spread_lim[i]) ; // no-op keeps loop index style simple
    for (int li = 0; li < 5; li++) begin
      int lim;
      lim = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 5 : (li == 3) ? 17 : 300;
      spread_lim = W'(lim);
      for (int sp = lim - 1; sp <= lim + 2; sp++) begin
        if (sp < 0) continue;
        rearm_pulse("R8 rearm before spread");
        step(1, 1000, 0, "R4 seed");
        step(1, 1000 + sp, 0, "R4 raise max");
        step(0, 0, 0, "R6 spread compare");
        step(1, 1000, 0, "R7 spread latch held");
        step(1, 1000 + sp / 2, 0, "R7 spread latch held");
        step(1, 999 - sp, 0, "R4 lower min");
        step(0, 0, 0, "R6 spread compare after min");
      end
    end

    // R5: samples with valid low are ignored
    spread_lim = 12'd10; over_lim = 12'd100;
    rearm_pulse("R8 clear");
    step(1, 60, 0, "R4 seed");
    for (int d = 0; d < 4096; d += 257) step(0, d, 0, "R5 invalid ignored");

    // R8: strobe level held high re-arms only once
    over_lim = 12'd4095; spread_lim = 12'd5;
    step(1, 200, 0, "R6 build spread");
    step(0, 0, 0, "R6 latched");
    step(0, 0, 1, "R8 held strobe");
    step(0, 0, 1, "R8 held strobe");
    step(0, 0, 1, "R8 edge acts");
    step(0, 0, 1, "R8 empty after edge");
    step(1, 10, 1, "R8 seed after edge");
    step(1, 30, 1, "R8 level no second rearm");
    step(0, 0, 1, "R8 latch again");
    step(1, 20, 1, "R7 still latched");
    step(0, 0, 0, "R7 still latched");

    // R10: valid sample coinciding with the re-arm edge
    for (int k = 0; k < 8; k++) begin
      step(0, 0, 1, "R10 strobe");
      step(0, 0, 0, "R10 sync");
      step(1, 500 + k * 37, 0, "R10 sample on edge");
      step(1, 500 + k * 37 + k, 0, "R10 after seed");
      step(0, 0, 0, "R10 spread check");
    end

    // R1: reset in mid-run clears everything
    step(1, 4000, 0, "R2 before reset");
    rst = 1;
    @(posedge clk); model_reset(); @(negedge clk);
    compare("R1 mid-run reset");
    rst = 0; mag_valid = 0;
    @(posedge clk); model_edge(); @(negedge clk);
    compare("R1 after mid-run reset");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule